// File: doc/BRIEF.md
# Three-Lane Interleaved Reed-Solomon Check-Byte Encoder

This block appends six forward-error-correction check bytes to each 256-byte flit. It accepts the 250 protected bytes of a flit as a byte stream. These bytes are the payload, the link-layer bytes and the CRC. The block passes each byte straight through to its output one cycle later.

While the bytes pass through, the block deals them in rotation into three independent Reed-Solomon codewords over GF(2^8). Each codeword has its own two-symbol remainder register. When the last protected byte has been taken, the block stops accepting input for six cycles. In those cycles it emits the parity symbols, interleaved across the three codewords. Spreading consecutive bytes over three codewords means a burst of up to three corrupted bytes hits each codeword at most once.

The upstream logic raises a start marker on byte 0 of every flit. It holds its byte until the ready output is high. A new flit may follow the previous one directly, so the output stream carries 256-byte flits with no idle cycles between them.

Top module: `fec_flit_encoder`

## Requirements
- R1: After reset, `out_valid`, `out_sof`, `out_eof` and `out_ecc` are low and `in_ready` is high.
- R2: A byte is taken in a cycle where `in_valid` and `in_ready` are both high. It appears on `out_data` in the next cycle with `out_valid` high and `out_ecc` low. A cycle in which no byte is taken and no check byte is due leaves `out_valid` low.
- R3: Position i of the protected region (i = 0 to 249, counted from the byte that carried `in_start`) belongs to codeword i mod 3. Codeword 0 therefore holds 84 data bytes, and codewords 1 and 2 hold 83 each.
- R4: Symbols are in GF(2^8) with reduction polynomial 0x11D and alpha = 0x02. The generator is (x+1)(x+alpha) = x^2 + 0x03·x + 0x02. Data bytes are the highest-degree coefficients, earliest byte first. Check byte "a" is the coefficient of x^1 and check byte "b" is the coefficient of x^0. Every codeword, evaluated at 1 and at alpha, gives zero.
- R5: The six cycles right after position 249 carry the check bytes in the order a0, a1, a2, b0, b1, b2, where the digit is the codeword index. These bytes have `out_ecc` high. `in_ready` is low in exactly those six cycles.
- R6: `out_sof` is high with output byte 0 of a flit. `out_eof` is high with output byte 255, which is check byte b2. The two are never high together.
- R7: A byte taken with `in_start` high is position 0, even in the middle of a flit. It clears all three remainders first, so the abandoned partial flit contributes nothing to any check byte and produces no check bytes.
- R8: Byte 0 of the next flit can be taken in the first cycle that `in_ready` is high again. Its output then follows check byte b2 with no gap.
- R9: Idle cycles (`in_valid` low) inside a flit do not change any check byte.
- R10: A byte offered while `in_ready` is low is not consumed. It is taken later, once `in_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_start | input | 1 | Input byte is position 0 of a flit |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can take an input byte this cycle |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte (data or check byte) |
| out_sof | output | 1 | Output byte is flit byte 0 |
| out_eof | output | 1 | Output byte is flit byte 255 |
| out_ecc | output | 1 | Output byte is a check byte |

## Verification
Two flits have check bytes worked out by hand. An all-zero flit must give six zero check bytes. A flit whose only non-zero byte is a 1 at position 249 must give 0x03 and 0x02 for codeword 0 and zeros elsewhere; a design with a wrong generator coefficient or with swapped a/b symbols fails here. For every flit, the bench evaluates all three received codewords at 1 and at alpha. A wrong lane rotation or a misordered check-byte slot leaves non-zero syndromes.

The bench also sends a flit directly after the previous one, a flit with idle gaps, and a flit cut short by a fresh start marker. A design that drops the byte held during the stall, leaves a gap between flits, or carries a stale remainder across the restart shows lost data, wrong cycle stamps or non-zero syndromes.

// File: rtl/fec_enc_pkg.sv
package fec_enc_pkg;

  localparam int SYM_W = 8;
  localparam logic [8:0] GF_POLY = 9'h11D;
  localparam int PAR_PER_CW = 2;

  typedef logic [SYM_W-1:0] sym_t;

  // generator g(x) = x^2 + GEN_C1*x + GEN_C0 = (x + 1)(x + alpha)
  localparam sym_t GEN_C1 = 8'h03;
  localparam sym_t GEN_C0 = 8'h02;

  typedef struct packed {
    sym_t hi;  // coefficient of x^1, first check symbol
    sym_t lo;  // coefficient of x^0, second check symbol
  } rem_t;

  function automatic sym_t gf_xtime(input sym_t a);
    logic [8:0] t;
    t = {a, 1'b0};
    if (t[8]) t = t ^ GF_POLY;
    return t[7:0];
  endfunction

  function automatic sym_t gf_mul(input sym_t a, input sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < SYM_W; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // one division step of the remainder register by g(x)
  function automatic rem_t rs_step(input rem_t r, input sym_t d);
    sym_t fb;
    rem_t n;
    fb   = d ^ r.hi;
    n.hi = r.lo ^ gf_mul(fb, GEN_C1);
    n.lo = gf_mul(fb, GEN_C0);
    return n;
  endfunction

endpackage

// File: rtl/fec_lane_seq.sv
module fec_lane_seq
  import fec_enc_pkg::*;
#(
  parameter int PROT_BYTES = 250,
  parameter int NUM_CW     = 3,
  parameter int ECC_BYTES  = 6,
  localparam int CW = $clog2(PROT_BYTES),
  localparam int LW = (NUM_CW > 1) ? $clog2(NUM_CW) : 1,
  localparam int EW = (ECC_BYTES > 1) ? $clog2(ECC_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_start,
  output logic          in_ready,
  output logic          byte_accept,
  output logic [LW-1:0] eff_lane,
  output logic          first_byte,
  output logic          last_data,
  output logic          ecc_emit,
  output logic [EW-1:0] ecc_idx,
  output logic          ecc_last
);

  logic [CW-1:0] byte_cnt;
  logic [LW-1:0] lane;
  logic          in_ecc;
  logic [CW-1:0] eff_cnt;

  assign in_ready    = !in_ecc;
  assign byte_accept = in_valid && in_ready;
  assign eff_cnt     = in_start ? '0 : byte_cnt;
  assign eff_lane    = in_start ? '0 : lane;
  assign first_byte  = (eff_cnt == '0);
  assign last_data   = byte_accept && (eff_cnt == CW'(PROT_BYTES - 1));
  assign ecc_emit    = in_ecc;
  assign ecc_last    = in_ecc && (ecc_idx == EW'(ECC_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_cnt <= '0;
      lane     <= '0;
      in_ecc   <= 1'b0;
      ecc_idx  <= '0;
    end else if (in_ecc) begin
      if (ecc_last) begin
        in_ecc  <= 1'b0;
        ecc_idx <= '0;
      end else begin
        ecc_idx <= ecc_idx + 1'b1;
      end
    end else if (byte_accept) begin
      if (last_data) begin
        byte_cnt <= '0;
        lane     <= '0;
        in_ecc   <= 1'b1;
        ecc_idx  <= '0;
      end else begin
        byte_cnt <= eff_cnt + 1'b1;
        lane     <= (eff_lane == LW'(NUM_CW - 1)) ? '0 : eff_lane + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fec_rs_rem.sv
module fec_rs_rem
  import fec_enc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  sym_t din,
  output rem_t rem
);

  rem_t base;

  assign base = clr ? '0 : rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
    end else if (en) begin
      rem <= rs_step(base, din);
    end else if (clr) begin
      rem <= '0;
    end
  end

endmodule

// File: rtl/fec_ecc_sel.sv
module fec_ecc_sel
  import fec_enc_pkg::*;
#(
  parameter int NUM_CW    = 3,
  parameter int ECC_BYTES = 6,
  localparam int EW = (ECC_BYTES > 1) ? $clog2(ECC_BYTES) : 1
) (
  input  rem_t          rems [NUM_CW],
  input  logic [EW-1:0] ecc_idx,
  output sym_t          ecc_byte
);

  // slot k: codeword k mod NUM_CW; first symbols in slots 0..NUM_CW-1, then second
  always_comb begin
    ecc_byte = '0;
    for (int k = 0; k < ECC_BYTES; k++) begin
      if (ecc_idx == EW'(k)) begin
        ecc_byte = (k < NUM_CW) ? rems[k % NUM_CW].hi : rems[k % NUM_CW].lo;
      end
    end
  end

endmodule

// File: rtl/fec_flit_encoder.sv
module fec_flit_encoder
  import fec_enc_pkg::*;
#(
  parameter int PROT_BYTES = 250,
  parameter int NUM_CW     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_start,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  output logic       out_ecc
);

  localparam int ECC_BYTES = PAR_PER_CW * NUM_CW;
  localparam int LW = (NUM_CW > 1) ? $clog2(NUM_CW) : 1;
  localparam int EW = (ECC_BYTES > 1) ? $clog2(ECC_BYTES) : 1;

  logic          byte_accept;
  logic [LW-1:0] eff_lane;
  logic          first_byte;
  logic          last_data;
  logic          ecc_emit;
  logic [EW-1:0] ecc_idx;
  logic          ecc_last;
  rem_t          rem_all [NUM_CW];
  sym_t          ecc_byte;

  fec_lane_seq #(
    .PROT_BYTES(PROT_BYTES),
    .NUM_CW    (NUM_CW),
    .ECC_BYTES (ECC_BYTES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_start   (in_start),
    .in_ready   (in_ready),
    .byte_accept(byte_accept),
    .eff_lane   (eff_lane),
    .first_byte (first_byte),
    .last_data  (last_data),
    .ecc_emit   (ecc_emit),
    .ecc_idx    (ecc_idx),
    .ecc_last   (ecc_last)
  );

  for (genvar c = 0; c < NUM_CW; c++) begin : g_cw
    fec_rs_rem u_rem (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (byte_accept && in_start),
      .en   (byte_accept && (eff_lane == LW'(c))),
      .din  (in_data),
      .rem  (rem_all[c])
    );
  end

  fec_ecc_sel #(
    .NUM_CW   (NUM_CW),
    .ECC_BYTES(ECC_BYTES)
  ) u_sel (
    .rems    (rem_all),
    .ecc_idx (ecc_idx),
    .ecc_byte(ecc_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_ecc   <= 1'b0;
    end else if (byte_accept) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_sof   <= first_byte;
      out_eof   <= 1'b0;
      out_ecc   <= 1'b0;
    end else if (ecc_emit) begin
      out_valid <= 1'b1;
      out_data  <= ecc_byte;
      out_sof   <= 1'b0;
      out_eof   <= ecc_last;
      out_ecc   <= 1'b1;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_ecc   <= 1'b0;
    end
  end

endmodule

// File: rtl/fec_flit_encoder_chk.sv
module fec_flit_encoder_chk #(
  parameter int ECC_BYTES = 6,
  localparam int RW = $clog2(ECC_BYTES + 2) + 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_start,
  input logic [7:0] in_data,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof,
  input logic       out_ecc,
  input logic       byte_accept,
  input logic       last_data
);

  logic [RW-1:0] nr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nr_run <= '0;
    else if (!in_ready) nr_run <= (nr_run == '1) ? nr_run : nr_run + 1'b1;
    else nr_run <= '0;
  end

  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    byte_accept |=> (out_valid && !out_ecc && out_data == $past(in_data)));

  a_r5_stall_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_data |=> !in_ready);

  a_r5_stall_window: assert property (@(posedge clk) disable iff (!rst_n)
    nr_run <= RW'(ECC_BYTES));

  a_r5_check_byte_out: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (out_valid && out_ecc));

  a_r6_eof_reopens: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> (in_ready && out_ecc));

  a_r6_marks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_sof && out_eof));

  a_r7_start_gives_sof: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_accept && in_start) |=> out_sof);

endmodule

bind fec_flit_encoder fec_flit_encoder_chk #(.ECC_BYTES(ECC_BYTES)) u_chk (.*);

// File: tb/sim_fec_flit_encoder.sv
module sim_fec_flit_encoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_start = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_sof;
  logic       out_eof;
  logic       out_ecc;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0] fl [0:6][0:249];
  logic [7:0] cap [0:2047];
  int         cap_cyc [0:2047];
  logic       cap_eof [0:2047];
  int         cap_n = 0;
  int         sof_pos [0:15];
  int         n_sof = 0;
  int         run = 0;

  always #2 clk = ~clk;

  fec_flit_encoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof), .out_ecc(out_ecc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] aa;
    logic [8:0] t;
    p = 0;
    aa = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p ^= aa;
      t = {aa, 1'b0};
      if (t[8]) t ^= 9'h11D;
      aa = t[7:0];
    end
    return p;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && cap_n < 2048) begin
        if (out_sof && n_sof < 16) begin
          sof_pos[n_sof] = cap_n;
          n_sof++;
        end
        cap[cap_n] = out_data;
        cap_cyc[cap_n] = cyc;
        cap_eof[cap_n] = out_eof;
        cap_n++;
      end
      if (!in_ready) run++;
      else if (run > 0) begin
        chk(run == 6, "R5 stall length", run, 6);
        run = 0;
      end
    end
  end

  task automatic send(input int k, input int n, input int gap);
    logic acc;
    for (int i = 0; i < n; i++) begin
      if (gap != 0 && (i % gap) == gap - 1) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_start = (i == 0);
      in_data  = fl[k][i];
      acc = 1'b0;
      while (!acc) begin
        acc = in_ready;
        @(negedge clk);
      end
    end
  endtask

  task automatic check_flit(input int f, input int k, input string tag);
    int b;
    int bad;
    logic [7:0] s0;
    logic [7:0] s1;
    logic [7:0] sym;
    b = sof_pos[f];
    bad = 0;
    for (int i = 0; i < 250; i++) if (cap[b + i] !== fl[k][i]) bad++;
    chk(bad == 0, {tag, " R2 R10 data bytes"}, bad, 0);
    chk(cap_eof[b + 255] === 1'b1, {tag, " R6 eof on byte 255"}, int'(cap_eof[b + 255]), 1);
    bad = 0;
    for (int j = 0; j < 6; j++) if (cap_cyc[b + 250 + j] != cap_cyc[b + 249] + 1 + j) bad++;
    chk(bad == 0, {tag, " R5 check bytes follow byte 249"}, bad, 0);
    for (int c = 0; c < 3; c++) begin
      s0 = 0;
      s1 = 0;
      for (int i = c; i < 250; i += 3) begin
        sym = cap[b + i];
        s0 ^= sym;
        s1 = bmul(s1, 8'h02) ^ sym;
      end
      sym = cap[b + 250 + c];
      s0 ^= sym;
      s1 = bmul(s1, 8'h02) ^ sym;
      sym = cap[b + 253 + c];
      s0 ^= sym;
      s1 = bmul(s1, 8'h02) ^ sym;
      chk(s0 == 0 && s1 == 0, {tag, " R3 R4 syndromes zero"}, int'({s1, s0}), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R5 run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int b;
    for (int i = 0; i < 250; i++) begin
      fl[0][i] = 8'h00;
      fl[1][i] = (i == 249) ? 8'h01 : 8'h00;
      fl[2][i] = 8'((i * 7 + 3) & 255);
      fl[3][i] = 8'(i) ^ 8'hA5;
      fl[4][i] = 8'((i * i) & 255);
      fl[5][i] = 8'((i * 29 + 1) & 255);
      fl[6][i] = 8'((i * 13) & 255) ^ 8'(i >> 3);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && out_sof == 1'b0 && out_eof == 1'b0 && out_ecc == 1'b0,
        "R1 outputs idle", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 no output while idle", int'(out_valid), 0);

    send(0, 250, 0);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    send(1, 250, 0);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    send(2, 250, 0);
    send(3, 250, 0);          // back-to-back, byte 0 held through the stall
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    send(4, 250, 5);          // idle gaps inside the flit
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    send(5, 100, 0);          // abandoned partial flit
    send(6, 250, 0);          // restart with a fresh start marker
    in_valid = 1'b0;
    in_start = 1'b0;
    repeat (12) @(negedge clk);

    chk(n_sof == 7, "R6 R7 start-of-flit count", n_sof, 7);
    if (n_sof == 7) begin
      b = sof_pos[0];
      for (int j = 0; j < 6; j++)
        chk(cap[b + 250 + j] == 8'h00, "R4 zero flit check byte", int'(cap[b + 250 + j]), 0);
      b = sof_pos[1];
      chk(cap[b + 250] == 8'h03, "R4 R5 a0 single-one flit", int'(cap[b + 250]), 3);
      chk(cap[b + 253] == 8'h02, "R4 R5 b0 single-one flit", int'(cap[b + 253]), 2);
      chk(cap[b + 251] == 0 && cap[b + 252] == 0 && cap[b + 254] == 0 && cap[b + 255] == 0,
          "R3 R5 other codewords zero", int'(cap[b + 251] | cap[b + 252] | cap[b + 254] | cap[b + 255]), 0);
      check_flit(0, 0, "zero");
      check_flit(1, 1, "single");
      check_flit(2, 2, "ramp");
      check_flit(3, 3, "R8 back-to-back");
      chk(cap_cyc[sof_pos[3]] == cap_cyc[sof_pos[3] - 1] + 1, "R8 no gap between flits",
          cap_cyc[sof_pos[3]] - cap_cyc[sof_pos[3] - 1], 1);
      check_flit(4, 4, "R9 gapped");
      chk(sof_pos[6] - sof_pos[5] == 100, "R7 partial flit gives no check bytes",
          sof_pos[6] - sof_pos[5], 100);
      check_flit(6, 6, "R7 restart");
      chk(cap_n == sof_pos[6] + 256, "R2 total output bytes", cap_n, sof_pos[6] + 256);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule